// File: doc/BRIEF.md
# Configurable TDM/I2S Serial Transmitter

This block turns parallel audio samples into a serial bit stream on one data line. It needs no clock of its own. A one-cycle bit strobe marks each bit period, and a sync input is sampled on that strobe. The sync input works as a left/right clock in two-channel I2S mode and as a frame sync pulse in multi-slot TDM mode. The block drives a new data bit only on strobe cycles.

Samples arrive on a valid/ready stream. The transmitter asks for a sample only at the start of a slot. At that moment it raises `s_ready` for the single strobe cycle, and it takes the word if `s_valid` is high. An upstream source that has no data ready only causes an empty (all-zero) slot; there is no other back-pressure. `s_data` must hold steady while `s_valid` is high and no handshake has happened. The control word and the TDM format word come from a register bank elsewhere and are expected to stay stable while a frame is in flight. A small gate keeps the interrupt enable that this port shares with its companion receiver.

Top module: `tdm_serial_tx`

## Requirements
- R1: After reset `sdo`, `s_ready`, `underflow` and `irq_en` are 0. A new frame starts only while `tx_ctl[0]` is 1. With `tx_ctl[0]` at 0 no sample is taken and `sdo` stays 0.
- R2: The sample-length code `tx_ctl[5:3]` maps 0 to 8 bits, 2 to 16, 4 to 24 and 5 to 32. Any other code blocks frame starts, so `s_ready` never rises and `sdo` stays 0.
- R3: In TDM mode the slot-width field `tdm_fmt[22:18]` holds 8, 16 or 24 directly, and 0 means 32 bits. Any other value blocks frame starts.
- R4: With `WIDE_SLOTS`=0 the slot count is `tdm_fmt[17:15]`, giving 1 to 7, with 0 meaning 8. With `WIDE_SLOTS`=1 it is `tdm_fmt[17:13]`, giving 1 to 31, with 0 meaning 32.
- R5: I2S mode (`tx_ctl[1]`=0): a frame begins where `sync_in` falls (left channel low). The right channel is loaded where it rises. The MSB of each channel is driven on the strobe after the edge.
- R6: TDM mode (`tx_ctl[1]`=1): `sync_in` seen high at a strobe after being low starts a frame. Slot 0's MSB is driven on the next strobe, and slots follow back to back. After the last slot `sdo` is 0.
- R7: A sample is the low N bits of `s_data`, with N from the sample-length code. It is sent MSB first from the first bit of its slot. Bits past N are 0, and a sample longer than its TDM slot is cut at the slot end.
- R8: `s_ready` is high only on a strobe cycle that starts a slot, so exactly one sample is taken per slot.
- R9: If `s_valid` is low when a slot starts, that slot is sent as zeros and `underflow` rises. It stays high until `uflow_clr` is pulsed.
- R10: Clearing `tx_ctl[0]` during a frame lets that frame finish. After that `sdo` idles at 0.
- R11: `irq_set` sets `irq_en`. `irq_en` is cleared on the cycle after `tx_ctl[0]` and `rx_en` are both 0, and never while either one is 1.
- R12: `sdo` changes only on the clock edge that follows a cycle with `bit_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| sync_in | input | 1 | Left/right clock (I2S) or frame sync (TDM), sampled on the strobe |
| tx_ctl | input | 8 | Control word: bit 0 run, bit 1 TDM, bits 5:3 sample-length code |
| tdm_fmt | input | 32 | TDM format word: slot width and slot count fields |
| rx_en | input | 1 | Enable of the companion receiver |
| irq_set | input | 1 | Pulse that sets the shared interrupt enable |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 32 | Sample, right-justified |
| uflow_clr | input | 1 | Pulse that clears the underflow flag |
| s_ready | output | 1 | Sample accepted this cycle (slot start) |
| sdo | output | 1 | Serial data out |
| underflow | output | 1 | Sticky: a slot started with no sample |
| irq_en | output | 1 | Shared interrupt enable |

## Verification
Some rules are checked on every cycle by assertions. `sdo` may move only after a strobe. `s_ready` may rise only on a strobe and never under an invalid length code. The underflow flag must hold until it is cleared. The interrupt enable must fall only after both enables are low, and a set must take hold while either enable is high. Bit order, left-justification, truncation, slot counts, the two framing styles and a clean finish after a stop can only be shown by the bench's scenarios. There, a bit-level model compares each serial bit with the samples handed over.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int SAMPLE_W  = 32;
  localparam int CNT_W     = $clog2(SAMPLE_W + 1);
  localparam int MAX_SLOTS = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

  // control word fields
  localparam int CTL_RUN    = 0;
  localparam int CTL_TDM    = 1;
  localparam int CTL_RES_LO = 3;
  localparam int CTL_RES_W  = 3;

  // format word fields
  localparam int FMT_WID_LO    = 18;
  localparam int FMT_WID_W     = 5;
  localparam int FMT_NSLOT_LO  = 15;
  localparam int FMT_NSLOT_W   = 3;
  localparam int FMT_WSLOT_LO  = 13;
  localparam int FMT_WSLOT_W   = 5;

  typedef struct packed {
    logic              run;
    logic              tdm;
    logic              ok;
    logic [CNT_W-1:0]  res;
    logic [CNT_W-1:0]  width;
    logic [SLOT_W-1:0] slots;
  } tx_cfg_t;

  function automatic logic [CNT_W-1:0] res_len(input logic [CTL_RES_W-1:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd2:    return CNT_W'(16);
      3'd4:    return CNT_W'(24);
      3'd5:    return CNT_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] slot_len(input logic [FMT_WID_W-1:0] f);
    case (f)
      5'd0:          return CNT_W'(32);
      5'd8, 5'd16,
      5'd24:         return CNT_W'(f);
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_cfg_decode.sv
module tdm_tx_cfg_decode
  import tdm_tx_pkg::*;
#(
  parameter bit WIDE_SLOTS = 1'b0
) (
  input  logic [7:0]  tx_ctl,
  input  logic [31:0] tdm_fmt,
  output tx_cfg_t     cfg
);
  logic [SLOT_W-1:0] slots_w;
  logic [CNT_W-1:0]  res_w;
  logic [CNT_W-1:0]  wid_w;

  generate
    if (WIDE_SLOTS) begin : g_wide
      logic [FMT_WSLOT_W-1:0] fld;
      assign fld     = tdm_fmt[FMT_WSLOT_LO +: FMT_WSLOT_W];
      assign slots_w = (fld == '0) ? SLOT_W'(MAX_SLOTS) : SLOT_W'(fld);
    end else begin : g_narrow
      logic [FMT_NSLOT_W-1:0] fld;
      assign fld     = tdm_fmt[FMT_NSLOT_LO +: FMT_NSLOT_W];
      assign slots_w = (fld == '0) ? SLOT_W'(1 << FMT_NSLOT_W) : SLOT_W'(fld);
    end
  endgenerate

  assign res_w = res_len(tx_ctl[CTL_RES_LO +: CTL_RES_W]);
  assign wid_w = slot_len(tdm_fmt[FMT_WID_LO +: FMT_WID_W]);

  always_comb begin
    cfg.run   = tx_ctl[CTL_RUN];
    cfg.tdm   = tx_ctl[CTL_TDM];
    cfg.res   = res_w;
    cfg.width = wid_w;
    cfg.slots = slots_w;
    cfg.ok    = (res_w != '0) && (!tx_ctl[CTL_TDM] || (wid_w != '0));
  end
endmodule

// File: rtl/tdm_tx_slot_seq.sv
module tdm_tx_slot_seq
  import tdm_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_tick,
  input  logic    sync_in,
  input  tx_cfg_t cfg,
  output logic    load,
  output logic    clear
);
  logic              sync_prev;
  logic              in_frame;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot_idx;

  logic rise, fall, go;
  logic i2s_start, i2s_right, i2s_stop;
  logic tdm_start, tdm_shift, slot_end, frame_end;

  assign rise = bit_tick &  sync_in & ~sync_prev;
  assign fall = bit_tick & ~sync_in &  sync_prev;
  assign go   = cfg.run & cfg.ok;

  assign i2s_start = ~cfg.tdm & fall & go;
  assign i2s_right = ~cfg.tdm & rise & in_frame & cfg.ok;
  assign i2s_stop  = ~cfg.tdm & fall & ~go;

  assign tdm_start = cfg.tdm & rise & go;
  assign tdm_shift = cfg.tdm & bit_tick & in_frame & ~tdm_start;
  assign slot_end  = tdm_shift & (bit_cnt == cfg.width - CNT_W'(1));
  assign frame_end = slot_end & (slot_idx == cfg.slots - SLOT_W'(1));

  assign load  = i2s_start | i2s_right | tdm_start | (slot_end & ~frame_end & cfg.ok);
  assign clear = i2s_stop | frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_prev <= 1'b0;
      in_frame  <= 1'b0;
      bit_cnt   <= '0;
      slot_idx  <= '0;
    end else begin
      if (bit_tick) sync_prev <= sync_in;
      if (i2s_start || tdm_start) begin
        in_frame <= 1'b1;
        bit_cnt  <= '0;
        slot_idx <= '0;
      end else if (i2s_stop || frame_end) begin
        in_frame <= 1'b0;
      end else if (slot_end) begin
        bit_cnt  <= '0;
        slot_idx <= slot_idx + SLOT_W'(1);
      end else if (tdm_shift) begin
        bit_cnt  <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter
  import tdm_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                load,
  input  logic                clear,
  input  logic [CNT_W-1:0]    res,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                uflow_clr,
  output logic                s_ready,
  output logic                sdo,
  output logic                underflow
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg;
  logic [CNT_W-1:0]    pad;
  logic [SAMPLE_W-1:0] aligned;

  assign s_ready = load;
  assign pad     = FULL - res;
  assign aligned = s_data << pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      sdo       <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (bit_tick) begin
        sdo <= shreg[SAMPLE_W-1];
        if (load)       shreg <= s_valid ? aligned : '0;
        else if (clear) shreg <= '0;
        else            shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
      end
      if (load && !s_valid) underflow <= 1'b1;
      else if (uflow_clr)   underflow <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_tx_irq_gate.sv
module tdm_tx_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_run,
  input  logic rx_run,
  input  logic irq_set,
  output logic irq_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_en <= 1'b0;
    else        irq_en <= (irq_en | irq_set) & (tx_run | rx_run);
  end
endmodule

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx
  import tdm_tx_pkg::*;
#(
  parameter bit WIDE_SLOTS = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        sync_in,
  input  logic [7:0]  tx_ctl,
  input  logic [31:0] tdm_fmt,
  input  logic        rx_en,
  input  logic        irq_set,
  input  logic        s_valid,
  input  logic [31:0] s_data,
  input  logic        uflow_clr,
  output logic        s_ready,
  output logic        sdo,
  output logic        underflow,
  output logic        irq_en
);
  tx_cfg_t cfg;
  logic    load, clear;

  tdm_tx_cfg_decode #(.WIDE_SLOTS(WIDE_SLOTS)) u_dec (
    .tx_ctl (tx_ctl),
    .tdm_fmt(tdm_fmt),
    .cfg    (cfg)
  );

  tdm_tx_slot_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_tick(bit_tick),
    .sync_in (sync_in),
    .cfg     (cfg),
    .load    (load),
    .clear   (clear)
  );

  tdm_tx_shifter u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .load     (load),
    .clear    (clear),
    .res      (cfg.res),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .uflow_clr(uflow_clr),
    .s_ready  (s_ready),
    .sdo      (sdo),
    .underflow(underflow)
  );

  tdm_tx_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_run (cfg.run),
    .rx_run (rx_en),
    .irq_set(irq_set),
    .irq_en (irq_en)
  );
endmodule

// File: rtl/tdm_serial_tx_chk.sv
module tdm_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic [7:0] tx_ctl,
  input logic       rx_en,
  input logic       irq_set,
  input logic       uflow_clr,
  input logic       s_ready,
  input logic       sdo,
  input logic       underflow,
  input logic       irq_en
);
  logic code_ok;
  assign code_ok = (tx_ctl[5:3] == 3'd0) || (tx_ctl[5:3] == 3'd2) ||
                   (tx_ctl[5:3] == 3'd4) || (tx_ctl[5:3] == 3'd5);

  AST_SDO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(sdo)); // R12

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick); // R8

  AST_NO_READY_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |-> !s_ready); // R2

  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !uflow_clr |=> underflow); // R9

  AST_IRQ_DROP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_en) |-> $past(!tx_ctl[0] && !rx_en)); // R11

  AST_IRQ_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set && (tx_ctl[0] || rx_en) |=> irq_en); // R11
endmodule

bind tdm_serial_tx tdm_serial_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .tx_ctl   (tx_ctl),
  .rx_en    (rx_en),
  .irq_set  (irq_set),
  .uflow_clr(uflow_clr),
  .s_ready  (s_ready),
  .sdo      (sdo),
  .underflow(underflow),
  .irq_en   (irq_en)
);

// File: tb/tdm_serial_tx_test.sv
module tdm_serial_tx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        sync_in = 1'b0;
  logic [7:0]  tx_ctl = '0;
  logic [31:0] tdm_fmt = '0;
  logic        rx_en = 1'b0;
  logic        irq_set = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data;
  logic        uflow_clr = 1'b0;
  logic        s_ready, sdo, underflow, irq_en;

  int n_chk = 0;
  int n_bad = 0;
  int hs_cnt = 0;
  int unstable = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_in(sync_in),
    .tx_ctl(tx_ctl), .tdm_fmt(tdm_fmt), .rx_en(rx_en), .irq_set(irq_set),
    .s_valid(s_valid), .s_data(s_data), .uflow_clr(uflow_clr),
    .s_ready(s_ready), .sdo(sdo), .underflow(underflow), .irq_en(irq_en)
  );

  function automatic logic [31:0] sample_of(int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic bit_of(logic [31:0] v, int pos, int r);
    if (pos < r) return v[r-1-pos];
    return 1'b0;
  endfunction

  function automatic logic [7:0] ctl_word(logic run, logic tdm, logic [2:0] code);
    return {2'b00, code, 1'b0, tdm, run};
  endfunction

  function automatic logic [31:0] fmt_word(logic [2:0] nslot, logic [4:0] wid);
    return (32'(wid) << 18) | (32'(nslot) << 15);
  endfunction

  assign s_data = sample_of(hs_cnt);

  always @(posedge clk)
    if (rst_n && s_valid && s_ready) hs_cnt <= hs_cnt + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic lv, output logic got);
    logic s1;
    @(negedge clk);
    sync_in  = lv;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    s1 = sdo;
    repeat (2) @(negedge clk);
    got = sdo;
    if (s1 !== got) unstable++;
  endtask

  task automatic test_reset();
    check("R1 reset sdo", sdo, 0);
    check("R1 reset s_ready", s_ready, 0);
    check("R1 reset underflow", underflow, 0);
    check("R1 reset irq_en", irq_en, 0);
  endtask

  // frame sync offered, but some setting must keep the port idle
  task automatic test_idle(string tag, logic [7:0] ctl, logic [31:0] fmt);
    logic got;
    int base;
    tx_ctl = ctl; tdm_fmt = fmt; s_valid = 1'b1;
    base = hs_cnt;
    step(1'b1, got);
    for (int i = 0; i < 20; i++) begin
      step(1'b0, got);
      check({tag, " sdo idle"}, got, 0);
    end
    check({tag, " no sample taken"}, hs_cnt, base);
  endtask

  task automatic test_tdm(string tag, logic [2:0] sf, logic [4:0] wf, logic [2:0] rcode,
                          int ns, int w, int r, logic valid);
    logic got;
    int base;
    tx_ctl = ctl_word(1'b1, 1'b1, rcode); tdm_fmt = fmt_word(sf, wf); s_valid = valid;
    base = hs_cnt;
    step(1'b1, got);
    check({tag, " R6 idle at sync"}, got, 0);
    for (int s = 0; s < ns; s++)
      for (int b = 0; b < w; b++) begin
        step(1'b0, got);
        check(valid ? {tag, " R7 slot bit"} : {tag, " R9 empty slot"}, got,
              valid ? bit_of(sample_of(base + s), b, r) : 1'b0);
      end
    for (int i = 0; i < 3; i++) begin
      step(1'b0, got);
      check({tag, " R6 zero after last slot"}, got, 0);
    end
    check({tag, " R8 samples per frame"}, hs_cnt, base + (valid ? ns : 0));
  endtask

  // I2S frames; run bit dropped mid right channel of the final frame
  task automatic test_i2s(string tag, int nfr, int h, logic [2:0] rcode, int r);
    logic got;
    logic [31:0] cur;
    int base, idx, pos;
    bit infr;
    tx_ctl = ctl_word(1'b1, 1'b0, rcode); s_valid = 1'b1;
    base = hs_cnt; idx = base; cur = '0; pos = 0; infr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      step(1'b1, got);
      check({tag, " R5 idle before frame"}, got, 0);
    end
    for (int f = 0; f < nfr; f++)
      for (int half = 0; half < 2; half++)
        for (int k = 0; k < h; k++) begin
          if (f == nfr - 1 && half == 1 && k == h / 2) tx_ctl[0] = 1'b0;
          step(half[0], got);
          check({tag, " R5 R7 channel bit"}, got, bit_of(cur, pos, r));
          pos++;
          if (k == 0) begin
            if (half == 0) begin
              if (tx_ctl[0]) begin cur = sample_of(idx); idx++; pos = 0; infr = 1'b1; end
              else begin cur = '0; infr = 1'b0; end
            end else if (infr) begin
              cur = sample_of(idx); idx++; pos = 0;
            end
          end
        end
    step(1'b0, got);
    check({tag, " R10 final bit of stopped frame"}, got, bit_of(cur, pos, r));
    for (int i = 0; i < 4; i++) begin
      step(1'b0, got);
      check({tag, " R10 idle after stop"}, got, 0);
    end
    check({tag, " R8 samples taken"}, hs_cnt, base + 2 * nfr);
  endtask

  task automatic test_underflow();
    logic got;
    check("R9 flag clear before", underflow, 0);
    test_tdm("uflow", 3'd2, 5'd8, 3'd0, 2, 8, 8, 1'b0);
    check("R9 flag set", underflow, 1);
    for (int i = 0; i < 3; i++) step(1'b0, got);
    check("R9 flag sticky", underflow, 1);
    @(negedge clk); uflow_clr = 1'b1;
    @(negedge clk); uflow_clr = 1'b0;
    check("R9 flag cleared", underflow, 0);
    s_valid = 1'b1;
  endtask

  task automatic test_irq();
    tx_ctl = ctl_word(1'b1, 1'b0, 3'd2); rx_en = 1'b0;
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    check("R11 set", irq_en, 1);
    rx_en = 1'b1; tx_ctl[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 held by receiver", irq_en, 1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 cleared when both idle", irq_en, 0);
    tx_ctl[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 no self-set", irq_en, 0);
    tx_ctl[0] = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_idle("R1 run off", ctl_word(1'b0, 1'b1, 3'd2), fmt_word(3'd2, 5'd16));
    test_tdm("R4 eight slots", 3'd0, 5'd8, 3'd0, 8, 8, 8, 1'b1);
    test_tdm("R3 width 32", 3'd3, 5'd0, 3'd4, 3, 32, 24, 1'b1);
    test_tdm("R7 truncate", 3'd2, 5'd16, 3'd5, 2, 16, 32, 1'b1);
    test_tdm("R3 width 24", 3'd1, 5'd24, 3'd2, 1, 24, 16, 1'b1);
    check("R9 no underflow with data", underflow, 0);
    test_i2s("i2s32", 2, 32, 3'd5, 32);
    test_i2s("i2s16", 2, 20, 3'd2, 16);
    test_i2s("i2s24 short", 1, 16, 3'd4, 24);
    test_idle("R2 bad code", ctl_word(1'b1, 1'b1, 3'd3), fmt_word(3'd2, 5'd16));
    test_idle("R3 bad width", ctl_word(1'b1, 1'b1, 3'd2), fmt_word(3'd2, 5'd12));
    test_underflow();
    test_irq();
    check("R12 sdo steady between strobes", unstable, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule